// File: doc/BRIEF.md
# AES3 Subframe Error Monitor

This block sits after a biphase decoder in a digital audio receiver and keeps a small error register about the incoming subframes. For every decoded subframe the decoder gives a one-cycle strobe with the 28 payload time slots (slots 4 to 31), a flag for a biphase coding violation, and the lock state of the clock recovery. From these the block works out five error conditions: parity, biphase, confidence, validity and loss of lock. It sets the matching bits in a sticky register, which changes only on subframe strobes.

The host clears the register by pulsing a read-clear input when it reads. A per-flag enable vector decides which flags count towards the combined receiver-error output that feeds the interrupt logic. Masked flags are still recorded. A hold-request output tells the audio path to repeat its previous sample for any subframe that carries an enabled error.

Top module: `aes_sf_err_mon`

## Requirements
- R1: The payload `sf_data` bit 0 is time slot 4 and bit 27 is time slot 31. A subframe strobe whose 28 payload bits hold an odd number of ones sets flag bit 0 (parity); an even count sets nothing.
- R2: A strobe with `bip_err` high sets flag bit 1 (biphase).
- R3: Flag bit 2 (confidence) is set by a strobe that has `bip_err` high or `lock_ok` low, or both.
- R4: Flag bit 3 (validity) is set by a strobe whose validity bit, time slot 28 (`sf_data` bit 24), is 1.
- R5: Flag bit 4 (unlock) is set by a strobe taken while `lock_ok` is low.
- R6: `err_flags` changes only on a clock edge with `sf_stb` or `rd_clr` high. A change of `lock_ok`, `bip_err` or `sf_data` between strobes has no effect.
- R7: Flags are sticky: they OR in the events of each later strobe. `rd_clr` alone clears them to zero. With `rd_clr` and `sf_stb` in the same cycle, the register holds only that subframe's events.
- R8: `rx_err` is high exactly when some set flag has its `err_en` bit at 1. A flag whose enable bit is 0 is still recorded in `err_flags`.
- R9: `hold_req` goes high in the cycle after a strobe whose events include an enabled flag, and stays at that value until the next strobe. It goes low after a strobe with no enabled event.
- R10: After reset, `err_flags` is 0, and `rx_err` and `hold_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sf_stb | input | 1 | One-cycle strobe marking a decoded subframe |
| sf_data | input | 28 | Time slots 4..31 of the subframe, bit 0 = slot 4 |
| bip_err | input | 1 | Biphase violation seen in this subframe (sampled on strobe) |
| lock_ok | input | 1 | Clock recovery locked (sampled on strobe) |
| rd_clr | input | 1 | Host read pulse; clears the sticky flags |
| err_en | input | 5 | Per-flag enable for rx_err and hold_req |
| err_flags | output | 5 | Sticky flags: 0 parity, 1 biphase, 2 confidence, 3 validity, 4 unlock |
| rx_err | output | 1 | OR of enabled set flags |
| hold_req | output | 1 | Repeat-previous-sample request for the current subframe |

## Verification
Every flag, and `hold_req`, is registered once. A strobe or clear driven in one cycle therefore shows its result on the first clock edge that samples it. `rx_err` then follows that register with no further delay. The driver applies each stimulus on the falling edge and queues the expected flags, hold and error values for that single cycle. The monitor compares them 2 ns after the next rising edge, so each check lands in the first cycle where the result is due. Idle cycles queue unchanged values, which checks that nothing moves between strobes.

// File: rtl/aes_mon_pkg.sv
package aes_mon_pkg;
    localparam int unsigned NFLAG    = 5;
    localparam int unsigned FLG_PAR  = 0;
    localparam int unsigned FLG_BIP  = 1;
    localparam int unsigned FLG_CONF = 2;
    localparam int unsigned FLG_VAL  = 3;
    localparam int unsigned FLG_UNLK = 4;

    typedef logic [NFLAG-1:0] flag_vec_t;

    typedef struct packed {
        flag_vec_t flags;
        logic      hold;
    } mon_state_t;
endpackage

// File: rtl/aes_sf_parity.sv
module aes_sf_parity #(
    parameter int unsigned W = 28
) (
    input  logic [W-1:0] data,
    output logic         odd
);
    logic [W:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_chain
        assign chain[i+1] = chain[i] ^ data[i];
    end
    assign odd = chain[W];
endmodule

// File: rtl/aes_sf_events.sv
module aes_sf_events
    import aes_mon_pkg::*;
(
    input  logic      par_odd,
    input  logic      bip_err,
    input  logic      lock_ok,
    input  logic      val_bit,
    output flag_vec_t ev
);
    always_comb begin
        ev           = '0;
        ev[FLG_PAR]  = par_odd;
        ev[FLG_BIP]  = bip_err;
        ev[FLG_UNLK] = ~lock_ok;
        ev[FLG_CONF] = bip_err | ~lock_ok;
        ev[FLG_VAL]  = val_bit;
    end
endmodule

// File: rtl/aes_sf_err_reg.sv
module aes_sf_err_reg
    import aes_mon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sf_stb,
    input  logic      rd_clr,
    input  flag_vec_t ev,
    input  flag_vec_t en,
    output flag_vec_t flags,
    output logic      rx_err,
    output logic      hold
);
    mon_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_clr) begin
            st_d.flags = '0;
        end
        if (sf_stb) begin
            st_d.flags = st_d.flags | ev;
            st_d.hold  = |(ev & en);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags  = st_q.flags;
    assign rx_err = |(st_q.flags & en);
    assign hold   = st_q.hold;

    // R6: no strobe and no clear leaves the register untouched
    p_quiet_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sf_stb && !rd_clr) |=> $stable(flags));

    // R7: a lone clear empties the register
    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !sf_stb) |=> (flags == '0));

    // R7: without a clear, set flags never drop
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr) |=> ((flags & $past(flags)) == $past(flags)));

    // R3: confidence never appears without biphase or unlock beside it
    p_conf_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_CONF]) |-> (flags[FLG_BIP] || flags[FLG_UNLK]));

    // R9: an enabled event raises hold and the error output next cycle
    p_hold_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_stb && |(ev & en)) |=> (hold && (rx_err || !$stable(en))));
endmodule

// File: rtl/aes_sf_err_mon.sv
module aes_sf_err_mon
    import aes_mon_pkg::*;
#(
    parameter int unsigned SLOT_LO = 4,
    parameter int unsigned SLOT_HI = 31,
    parameter int unsigned V_SLOT  = 28
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sf_stb,
    input  logic [SLOT_HI-SLOT_LO:0]   sf_data,
    input  logic                       bip_err,
    input  logic                       lock_ok,
    input  logic                       rd_clr,
    input  logic [NFLAG-1:0]           err_en,
    output logic [NFLAG-1:0]           err_flags,
    output logic                       rx_err,
    output logic                       hold_req
);
    localparam int unsigned SF_W  = SLOT_HI - SLOT_LO + 1;
    localparam int unsigned V_IDX = V_SLOT - SLOT_LO;

    logic      par_odd;
    flag_vec_t ev;

    aes_sf_parity #(.W(SF_W)) u_par (
        .data (sf_data),
        .odd  (par_odd)
    );

    aes_sf_events u_ev (
        .par_odd (par_odd),
        .bip_err (bip_err),
        .lock_ok (lock_ok),
        .val_bit (sf_data[V_IDX]),
        .ev      (ev)
    );

    aes_sf_err_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sf_stb (sf_stb),
        .rd_clr (rd_clr),
        .ev     (ev),
        .en     (err_en),
        .flags  (err_flags),
        .rx_err (rx_err),
        .hold   (hold_req)
    );

    // R1: odd payload weight on a strobe leaves the parity flag set
    p_parity_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_stb && (^sf_data)) |=> err_flags[FLG_PAR]);

    // R5: a strobe while unlocked leaves the unlock flag set
    p_unlock_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_stb && !lock_ok) |=> err_flags[FLG_UNLK]);
endmodule

// File: tb/sim_aes_sf_err_mon.sv
module sim_aes_sf_err_mon;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sf_stb = 1'b0;
    logic [27:0] sf_data = '0;
    logic        bip_err = 1'b0;
    logic        lock_ok = 1'b1;
    logic        rd_clr = 1'b0;
    logic [4:0]  err_en = 5'b11111;
    logic [4:0]  err_flags;
    logic        rx_err;
    logic        hold_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [4:0] f;
        logic       h;
        logic       r;
        string      tag;
    } exp_t;
    exp_t q[$];

    logic [4:0] m_flags = '0;
    logic       m_hold  = 1'b0;

    always #4 clk = ~clk;

    aes_sf_err_mon u0 (
        .clk(clk), .rst_n(rst_n), .sf_stb(sf_stb), .sf_data(sf_data),
        .bip_err(bip_err), .lock_ok(lock_ok), .rd_clr(rd_clr),
        .err_en(err_en), .err_flags(err_flags), .rx_err(rx_err),
        .hold_req(hold_req)
    );

    function automatic logic [27:0] mk(input logic [26:0] body, input logic good);
        return {(^body) ^ ~good, body};
    endfunction

    task automatic step(input logic stb, input logic [27:0] d, input logic bip,
                        input logic lk, input logic clr, input logic [4:0] en,
                        input string tag);
        logic [4:0] ev;
        exp_t e;
        @(negedge clk);
        sf_stb = stb; sf_data = d; bip_err = bip; lock_ok = lk;
        rd_clr = clr; err_en = en;
        ev = {~lk, d[24], bip | ~lk, bip, ^d};
        if (clr) m_flags = '0;
        if (stb) begin
            m_flags = m_flags | ev;
            m_hold  = |(ev & en);
        end
        e.f = m_flags; e.h = m_hold; e.r = |(m_flags & en); e.tag = tag;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (err_flags !== e.f || hold_req !== e.h || rx_err !== e.r) begin
                errors++;
                $display("FAIL %s: flags=%b hold=%b rx_err=%b expected flags=%b hold=%b rx_err=%b",
                         e.tag, err_flags, hold_req, rx_err, e.f, e.h, e.r);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [26:0] lf;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (err_flags !== 5'b0 || rx_err !== 1'b0 || hold_req !== 1'b0) begin
            errors++;
            $display("FAIL R10: flags=%b rx_err=%b hold=%b expected 00000 0 0",
                     err_flags, rx_err, hold_req);
        end
        @(negedge clk); rst_n = 1'b1;

        step(1, mk(27'h0123456, 1), 0, 1, 0, 5'h1F, "R1 clean subframe");
        step(1, mk(27'h0000001, 0), 0, 1, 0, 5'h1F, "R1 R9 parity error");
        step(0, '0, 0, 1, 0, 5'h1F, "R6 R9 idle keeps flags and hold");
        step(1, mk(27'h0, 1), 0, 1, 0, 5'h1F, "R7 sticky across clean, R9 hold drops");
        step(0, '0, 0, 1, 1, 5'h1F, "R7 lone clear");
        step(1, mk(27'h3, 1), 1, 1, 0, 5'h1F, "R2 R3 biphase sets conf");
        step(1, mk(27'h1000000, 1), 0, 1, 1, 5'h1F, "R4 R7 clear with strobe keeps only validity");
        step(0, '0, 0, 1, 1, 5'h1F, "R7 clear");
        step(0, mk(27'h1000000, 0), 1, 0, 0, 5'h1F, "R6 inputs between strobes ignored");
        step(1, mk(27'h5, 1), 0, 0, 0, 5'h1F, "R5 R3 unlock sets conf");
        step(0, '0, 0, 1, 1, 5'h1F, "R7 clear");
        step(1, mk(27'h7, 0), 0, 1, 0, 5'b11110, "R8 masked parity recorded, no rx_err");
        step(0, '0, 0, 1, 0, 5'b11111, "R8 enabling parity raises rx_err");
        step(1, mk(27'h1000000, 1), 1, 1, 1, 5'b01000, "R8 R9 only validity enabled");
        step(1, mk(27'h0, 1), 1, 1, 1, 5'b01000, "R9 biphase masked, no hold");
        lf = 27'h5A5A5A5;
        for (int i = 0; i < 12; i++) begin
            lf = {lf[25:0], lf[26] ^ lf[25] ^ lf[0]};
            step(1, mk(lf, i[0]), 0, 1, 1, 5'h1F, "R1 R4 varied payload");
        end
        step(0, '0, 0, 1, 0, 5'h1F, "R6 final idle");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule